// File: doc/BRIEF.md
# Platform System I/O Register Bank

This block is a small bank of byte-wide control and status registers reached through port addresses on a legacy PC-style I/O bus. A bus master presents a 16-bit port address with a read or write strobe and 8-bit write data. Reads return data in the same cycle. Writes take effect on the clock edge that samples the strobe. The bank holds three stored registers:

- a soft-reset latch;
- a system-control register that keeps only its upper nibble;
- an I/O-map-type register that keeps only its lowest bit.

It also returns two board strap values taken from input pins. Several write-only ports swallow their data. The stored registers drive side-band outputs directly, so those outputs move in the same cycle as the register they mirror. Architectural bit numbering is reversed: bit n of a register has byte weight 1<<(7-n).

A request for little-endian byte order at the soft-reset port is not supported. Such a write sets a sticky error flag and changes nothing else. This flag is a two-state machine. State `ORD_NORMAL` is entered at reset. The transition `le_request` (a write to port 0x092 with value bit 0x02 set) moves it to `ORD_FAULT`. The transition `hold` keeps it in `ORD_FAULT` until the next reset.

Beside the port space, a separate 32-bit memory-mapped parity status word reads as zero. It accepts only full-word accesses.

Top module: `sysio_regbank`

## Requirements
- R1: After reset, port 0x092 reads 0x00, port 0x81C reads 0x00 and port 0x850 reads 0x01. After reset, `soft_reset_o` is 0, `noncontig_map_o` is 1 and `order_err_o` is 0.
- R2: A write to port 0x092 with value bit 0x02 clear stores only bit 0x01. A later read of port 0x092 returns the data masked with 0x01. `soft_reset_o` equals the stored bit from the cycle after the write edge.
- R3: A write to port 0x092 with bit 0x02 set raises `order_err_o` after the write edge and leaves the stored soft-reset bit and `soft_reset_o` unchanged. `order_err_o` stays high through any later writes until reset.
- R4: Port 0x81C stores only bits 0xF0 of written data. The other bits read back as zero.
- R5: Port 0x850 stores only bit 0x01 of written data. After every write to it, `noncontig_map_o` equals that bit.
- R6: A read of port 0x80C returns the current `strap_equip` value. A read of port 0x852 returns the current `strap_board` value.
- R7: Port 0x818 always reads 0x00, including after it has been written.
- R8: Writes to ports 0x808, 0x810, 0x812, 0x814 or to any unmapped port change no stored register and no side-band output.
- R9: Reads of write-only or unmapped ports return 0xFF and change no state. `io_rdata` is 0xFF whenever `io_rd` is low.
- R10: A read at the word containing address 0xBFFFEFF0 with `mem_be` = 4'hF raises `mem_ack` with `mem_rdata` = 0. A read there with any other byte-enable raises `mem_err` instead. A read at any other address raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, same cycle as `io_rd` |
| mem_addr | input | 32 | Memory read address |
| mem_rd | input | 1 | Memory read strobe |
| mem_be | input | 4 | Memory byte enables |
| mem_rdata | output | 32 | Parity status word |
| mem_ack | output | 1 | Valid full-word parity access |
| mem_err | output | 1 | Parity access with wrong size |
| strap_equip | input | 8 | Equipment strap value |
| strap_board | input | 8 | Board identifier strap value |
| soft_reset_o | output | 1 | Soft-reset request, mirrors port 0x092 bit 0x01 |
| noncontig_map_o | output | 1 | Non-contiguous map select, mirrors port 0x850 bit 0x01 |
| order_err_o | output | 1 | Sticky unsupported byte-order request flag |

## Verification
Read data, `mem_ack` and `mem_err` are combinational. They are due in the same cycle as the strobe, so the bench raises the strobe at a falling edge and samples two nanoseconds later, before the next rising edge. Stored values, `soft_reset_o`, `noncontig_map_o` and `order_err_o` change on the rising edge that samples `io_wr`. The bench therefore holds the strobe for exactly one rising edge and checks these values at the falling edge that follows it, or through a read started there.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

    // Architectural bit n has byte weight 1 << (7 - n).
    function automatic logic [7:0] arch_bit(input int n);
        return 8'h01 << (7 - n);
    endfunction

    localparam logic [15:0] PORT_SRESET  = 16'h0092;
    localparam logic [15:0] PORT_EQUIP   = 16'h080C;
    localparam logic [15:0] PORT_KEYLOCK = 16'h0818;
    localparam logic [15:0] PORT_SYSCTL  = 16'h081C;
    localparam logic [15:0] PORT_MAPTYPE = 16'h0850;
    localparam logic [15:0] PORT_BOARD   = 16'h0852;

    localparam int NUM_WO = 4;
    localparam logic [15:0] WO_PORTS [NUM_WO] = '{16'h0808, 16'h0810, 16'h0812, 16'h0814};

    localparam logic [7:0] SR_KEEP   = arch_bit(7);
    localparam logic [7:0] LE_REQ    = arch_bit(6);
    localparam logic [7:0] CTL_KEEP  = arch_bit(0) | arch_bit(1) | arch_bit(2) | arch_bit(3);
    localparam logic [7:0] MAP_KEEP  = arch_bit(7);
    localparam logic [7:0] MAP_RESET = MAP_KEEP;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SRESET,
        SEL_EQUIP,
        SEL_KEYLOCK,
        SEL_SYSCTL,
        SEL_MAPTYPE,
        SEL_BOARD,
        SEL_WO
    } port_sel_e;

    typedef enum logic {
        ORD_NORMAL,
        ORD_FAULT
    } order_state_e;

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
    import sysio_pkg::*;
#(
    parameter int IO_AW = 16
) (
    input  logic [IO_AW-1:0] io_addr,
    output port_sel_e        sel
);

    logic [NUM_WO-1:0] wo_hit;

    for (genvar gi = 0; gi < NUM_WO; gi++) begin : g_wo
        assign wo_hit[gi] = (io_addr == IO_AW'(WO_PORTS[gi]));
    end

    always_comb begin
        sel = SEL_NONE;
        if (|wo_hit)                             sel = SEL_WO;
        else if (io_addr == IO_AW'(PORT_SRESET))  sel = SEL_SRESET;
        else if (io_addr == IO_AW'(PORT_EQUIP))   sel = SEL_EQUIP;
        else if (io_addr == IO_AW'(PORT_KEYLOCK)) sel = SEL_KEYLOCK;
        else if (io_addr == IO_AW'(PORT_SYSCTL))  sel = SEL_SYSCTL;
        else if (io_addr == IO_AW'(PORT_MAPTYPE)) sel = SEL_MAPTYPE;
        else if (io_addr == IO_AW'(PORT_BOARD))   sel = SEL_BOARD;
    end

endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
    import sysio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  port_sel_e  sel,
    input  logic       io_wr,
    input  logic [7:0] io_wdata,
    output logic [7:0] sreset_q,
    output logic [7:0] sysctl_q,
    output logic [7:0] map_q,
    output logic       soft_reset_o,
    output logic       noncontig_map_o,
    output logic       order_err_o
);

    order_state_e state_q, state_d;
    logic         le_write;
    logic         sr_write;

    assign le_write = io_wr && (sel == SEL_SRESET) && ((io_wdata & LE_REQ) != 8'h00);
    assign sr_write = io_wr && (sel == SEL_SRESET) && ((io_wdata & LE_REQ) == 8'h00);

    // Stored registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreset_q <= 8'h00;
            sysctl_q <= 8'h00;
            map_q    <= MAP_RESET;
        end else begin
            if (sr_write)
                sreset_q <= io_wdata & SR_KEEP;
            if (io_wr && sel == SEL_SYSCTL)
                sysctl_q <= io_wdata & CTL_KEEP;
            if (io_wr && sel == SEL_MAPTYPE)
                map_q <= io_wdata & MAP_KEEP;
        end
    end

    // Byte-order fault state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ORD_NORMAL;
        else        state_q <= state_d;
    end

    // Transitions: le_request (NORMAL -> FAULT), hold (FAULT -> FAULT)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ORD_NORMAL: if (le_write) state_d = ORD_FAULT;
            ORD_FAULT:  state_d = ORD_FAULT;
        endcase
    end

    // Outputs
    always_comb begin
        order_err_o     = (state_q == ORD_FAULT);
        soft_reset_o    = |(sreset_q & SR_KEEP);
        noncontig_map_o = |(map_q & MAP_KEEP);
    end

    a_r2_sreset_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sr_write |=> (soft_reset_o == $past(io_wdata[0])));

    a_r3_le_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        le_write |=> ($stable(soft_reset_o) && order_err_o));

    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        order_err_o |=> order_err_o);

    a_r4_ctl_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && sel == SEL_SYSCTL) |=> (sysctl_q == ($past(io_wdata) & 8'hF0)));

    a_r5_map_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && sel == SEL_MAPTYPE) |=> (noncontig_map_o == $past(io_wdata[0])));

    a_r8_wo_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && (sel == SEL_WO || sel == SEL_NONE)) |=>
            ($stable(sreset_q) && $stable(sysctl_q) && $stable(map_q) && $stable(order_err_o)));

endmodule

// File: rtl/sysio_rdmux.sv
module sysio_rdmux
    import sysio_pkg::*;
#(
    parameter int              MEM_AW      = 32,
    parameter logic [MEM_AW-1:0] PARITY_BASE = 32'hBFFF_EFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_sel_e         sel,
    input  logic              io_rd,
    input  logic [7:0]        sreset_q,
    input  logic [7:0]        sysctl_q,
    input  logic [7:0]        map_q,
    input  logic [7:0]        strap_equip,
    input  logic [7:0]        strap_board,
    output logic [7:0]        io_rdata,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_rd,
    input  logic [3:0]        mem_be,
    output logic [31:0]       mem_rdata,
    output logic              mem_ack,
    output logic              mem_err
);

    localparam int WORD_LSB = 2;

    logic parity_hit;

    assign parity_hit = mem_rd && (mem_addr[MEM_AW-1:WORD_LSB] == PARITY_BASE[MEM_AW-1:WORD_LSB]);

    always_comb begin
        io_rdata = IDLE_BYTE;
        if (io_rd) begin
            unique case (sel)
                SEL_SRESET:  io_rdata = sreset_q;
                SEL_EQUIP:   io_rdata = strap_equip;
                SEL_KEYLOCK: io_rdata = 8'h00;
                SEL_SYSCTL:  io_rdata = sysctl_q;
                SEL_MAPTYPE: io_rdata = map_q;
                SEL_BOARD:   io_rdata = strap_board;
                SEL_WO:      io_rdata = IDLE_BYTE;
                SEL_NONE:    io_rdata = IDLE_BYTE;
            endcase
        end
    end

    always_comb begin
        mem_ack   = parity_hit && (mem_be == 4'hF);
        mem_err   = parity_hit && (mem_be != 4'hF);
        mem_rdata = 32'h0000_0000;
    end

    a_r7_keylock_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && sel == SEL_KEYLOCK) |-> (io_rdata == 8'h00));

    a_r10_full_word_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ack |-> (mem_be == 4'hF && !mem_err));

endmodule

// File: rtl/sysio_regbank.sv
module sysio_regbank
    import sysio_pkg::*;
#(
    parameter int                IO_AW       = 16,
    parameter int                MEM_AW      = 32,
    parameter logic [MEM_AW-1:0] PARITY_BASE = 32'hBFFF_EFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_rd,
    input  logic [3:0]        mem_be,
    output logic [31:0]       mem_rdata,
    output logic              mem_ack,
    output logic              mem_err,
    input  logic [7:0]        strap_equip,
    input  logic [7:0]        strap_board,
    output logic              soft_reset_o,
    output logic              noncontig_map_o,
    output logic              order_err_o
);

    port_sel_e  sel;
    logic [7:0] sreset_q, sysctl_q, map_q;

    sysio_decode #(.IO_AW(IO_AW)) u_decode (
        .io_addr (io_addr),
        .sel     (sel)
    );

    sysio_regs u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .sel             (sel),
        .io_wr           (io_wr),
        .io_wdata        (io_wdata),
        .sreset_q        (sreset_q),
        .sysctl_q        (sysctl_q),
        .map_q           (map_q),
        .soft_reset_o    (soft_reset_o),
        .noncontig_map_o (noncontig_map_o),
        .order_err_o     (order_err_o)
    );

    sysio_rdmux #(.MEM_AW(MEM_AW), .PARITY_BASE(PARITY_BASE)) u_rdmux (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .io_rd       (io_rd),
        .sreset_q    (sreset_q),
        .sysctl_q    (sysctl_q),
        .map_q       (map_q),
        .strap_equip (strap_equip),
        .strap_board (strap_board),
        .io_rdata    (io_rdata),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_be      (mem_be),
        .mem_rdata   (mem_rdata),
        .mem_ack     (mem_ack),
        .mem_err     (mem_err)
    );

endmodule

// File: tb/sysio_regbank_tb.sv
module sysio_regbank_tb_top;

    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  val;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0092, 8'h81, 8'd2},  // R2 write, LE bit clear
        '{1'b1, 16'h0092, 8'h01, 8'd2},  // R2
        '{1'b0, 16'h0092, 8'hFC, 8'd2},  // R2
        '{1'b1, 16'h0092, 8'h00, 8'd2},  // R2
        '{1'b0, 16'h081C, 8'hFF, 8'd4},  // R4
        '{1'b1, 16'h081C, 8'hF0, 8'd4},  // R4
        '{1'b0, 16'h081C, 8'h3C, 8'd4},  // R4
        '{1'b1, 16'h081C, 8'h30, 8'd4},  // R4
        '{1'b0, 16'h0850, 8'hFE, 8'd5},  // R5
        '{1'b1, 16'h0850, 8'h00, 8'd5},  // R5
        '{1'b0, 16'h0850, 8'h81, 8'd5},  // R5
        '{1'b1, 16'h0850, 8'h01, 8'd5},  // R5
        '{1'b1, 16'h080C, 8'hA5, 8'd6},  // R6
        '{1'b1, 16'h0852, 8'h3C, 8'd6},  // R6
        '{1'b0, 16'h0818, 8'hFF, 8'd7},  // R7 write to read-only
        '{1'b1, 16'h0818, 8'h00, 8'd7},  // R7
        '{1'b1, 16'h0808, 8'hFF, 8'd9},  // R9
        '{1'b1, 16'h0812, 8'hFF, 8'd9},  // R9
        '{1'b1, 16'h0814, 8'hFF, 8'd9},  // R9
        '{1'b1, 16'h0123, 8'hFF, 8'd9}   // R9 unmapped
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic [31:0] mem_addr = 32'h0;
    logic        mem_rd = 1'b0;
    logic [3:0]  mem_be = 4'h0;
    logic [31:0] mem_rdata;
    logic        mem_ack, mem_err;
    logic [7:0]  strap_equip = 8'hA5;
    logic [7:0]  strap_board = 8'h3C;
    logic        soft_reset_o, noncontig_map_o, order_err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sysio_regbank dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .io_addr         (io_addr),
        .io_rd           (io_rd),
        .io_wr           (io_wr),
        .io_wdata        (io_wdata),
        .io_rdata        (io_rdata),
        .mem_addr        (mem_addr),
        .mem_rd          (mem_rd),
        .mem_be          (mem_be),
        .mem_rdata       (mem_rdata),
        .mem_ack         (mem_ack),
        .mem_err         (mem_err),
        .strap_equip     (strap_equip),
        .strap_board     (strap_board),
        .soft_reset_o    (soft_reset_o),
        .noncontig_map_o (noncontig_map_o),
        .order_err_o     (order_err_o)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2;
        d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic mem_read(input logic [31:0] a, input logic [3:0] be);
        @(negedge clk);
        mem_addr = a; mem_be = be; mem_rd = 1'b1;
        #2;
    endtask

    task automatic side(input string req, input logic sr, input logic mp, input logic er);
        check(req, "soft_reset_o", 32'(soft_reset_o), 32'(sr));
        check(req, "noncontig_map_o", 32'(noncontig_map_o), 32'(mp));
        check(req, "order_err_o", 32'(order_err_o), 32'(er));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        io_read(16'h0092, rd); check("R1", "0x092 reset", 32'(rd), 32'h00);
        io_read(16'h081C, rd); check("R1", "0x81C reset", 32'(rd), 32'h00);
        io_read(16'h0850, rd); check("R1", "0x850 reset", 32'(rd), 32'h01);
        side("R1", 1'b0, 1'b1, 1'b0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                io_read(VECS[i].addr, rd);
                check($sformatf("R%0d", VECS[i].req), $sformatf("read 0x%0h", VECS[i].addr),
                      32'(rd), 32'(VECS[i].val));
            end else begin
                io_write(VECS[i].addr, VECS[i].val);
            end
        end

        // R2 side-band follows soft-reset bit
        io_write(16'h0092, 8'h01); side("R2", 1'b1, 1'b1, 1'b0);
        io_write(16'h0092, 8'h00); side("R2", 1'b0, 1'b1, 1'b0);

        // R5 side-band follows map bit
        io_write(16'h0850, 8'h00); side("R5", 1'b0, 1'b0, 1'b0);
        io_write(16'h0850, 8'h01); side("R5", 1'b0, 1'b1, 1'b0);

        // R8 writes to write-only and unmapped ports
        io_write(16'h0092, 8'h01);
        io_write(16'h081C, 8'hA0);
        io_write(16'h0850, 8'h00);
        io_write(16'h0808, 8'hFF);
        io_write(16'h0810, 8'hFF);
        io_write(16'h0812, 8'hFF);
        io_write(16'h0814, 8'hFF);
        io_write(16'h0093, 8'hFF);
        io_write(16'h0851, 8'hFF);
        io_read(16'h0092, rd); check("R8", "0x092 kept", 32'(rd), 32'h01);
        io_read(16'h081C, rd); check("R8", "0x81C kept", 32'(rd), 32'hA0);
        io_read(16'h0850, rd); check("R8", "0x850 kept", 32'(rd), 32'h00);
        side("R8", 1'b1, 1'b0, 1'b0);

        // R9 reads of write-only ports leave state, idle data is 0xFF
        io_read(16'h0810, rd); check("R9", "read 0x810", 32'(rd), 32'hFF);
        io_read(16'hFFFF, rd); check("R9", "read 0xFFFF", 32'(rd), 32'hFF);
        side("R9", 1'b1, 1'b0, 1'b0);
        @(negedge clk); io_addr = 16'h081C; #2;
        check("R9", "idle rdata", 32'(io_rdata), 32'hFF);

        // R6 straps are live
        strap_equip = 8'h5A; strap_board = 8'hC3;
        io_read(16'h080C, rd); check("R6", "equip live", 32'(rd), 32'h5A);
        io_read(16'h0852, rd); check("R6", "board live", 32'(rd), 32'hC3);

        // R10 parity word
        mem_read(32'hBFFF_EFF0, 4'hF);
        check("R10", "ack full", 32'(mem_ack), 32'h1);
        check("R10", "err full", 32'(mem_err), 32'h0);
        check("R10", "rdata", mem_rdata, 32'h0);
        mem_read(32'hBFFF_EFF2, 4'h3);
        check("R10", "ack half", 32'(mem_ack), 32'h0);
        check("R10", "err half", 32'(mem_err), 32'h1);
        mem_read(32'hBFFF_EFF4, 4'hF);
        check("R10", "ack miss", 32'(mem_ack), 32'h0);
        check("R10", "err miss", 32'(mem_err), 32'h0);
        @(negedge clk); mem_rd = 1'b0;

        // R3 little-endian request, soft-reset bit held at 1
        io_write(16'h0092, 8'h02);
        side("R3", 1'b1, 1'b0, 1'b1);
        io_read(16'h0092, rd); check("R3", "0x092 unchanged", 32'(rd), 32'h01);
        io_write(16'h0092, 8'h00);
        side("R3", 1'b0, 1'b0, 1'b1);
        io_write(16'h0092, 8'h03);
        side("R3", 1'b0, 1'b0, 1'b1);

        // R1 reset clears the fault and restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        side("R1", 1'b0, 1'b1, 1'b0);
        io_read(16'h0850, rd); check("R1", "0x850 after reset", 32'(rd), 32'h01);

        summary();
    end

endmodule